// File: doc/BRIEF.md
# Consecutive-Zero Discharge Controller

This block sits behind a radio receiver's bit recovery and watches the recovered serial stream. It counts zero bits that arrive back to back. When the count reaches a programmed threshold, two separately enabled actions may follow. The first is a timed discharge pulse on the transceiver direction pin, which resets the data slicer's reference capacitor. The second is a sticky link-idle interrupt, which tells the host that an unidentified transmission on the channel has ended.

A second discharge source is a plain request input with its own enable. Both sources share one pulse timer. Software sets the pulse length in clocks so that the pulse lasts about 3 µs at the clock frequency in use. All configuration inputs pass through a register stage that returns to defaults on reset.

Top module: `zeroDischargeCtrl`

## Requirements
- R1: While reset is low, and after it is released, the pin and the interrupt are 0 and the zero count is cleared. The registered configuration defaults are: both discharge enables off, interrupt enable off, threshold code 0, period 0.
- R2: The zero count changes only in a cycle with `bitValid`=1. A valid 1 bit clears the count. Cycles with `bitValid`=0 leave the count unchanged, whatever `bitData` holds.
- R3: A threshold code n (0..7) makes n+1 consecutive valid zero bits one event. The event occurs in the cycle of the (n+1)-th zero.
- R4: The count saturates at the threshold, so a longer run of zeros gives only one event until a valid 1 bit arrives.
- R5: An event starts a discharge pulse only when the registered zero-discharge enable is 1.
- R6: An event sets `idleIrq` on the next clock edge when the registered interrupt enable is 1, even if the zero-discharge enable is 0.
- R7: `idleIrq` stays set until `irqClear` is 1 in a cycle without a new event. A clear and an event in the same cycle leave it set.
- R8: A pulse drives `dischargePin` to 1 for exactly P clocks, where P is the registered period, or 1 when the period is 0. The pin then returns to 0.
- R9: `capDisReq`=1 starts the same pulse when the registered request enable is 1, and has no effect when it is 0.
- R10: A trigger from either source that arrives while a pulse is running is ignored and does not lengthen the pulse.
- R11: A configuration input takes effect one clock after it is applied. A bit or request sampled on that same edge still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | Strobe: recovered bit present this cycle |
| bitData | input | 1 | Recovered bit value |
| zeroDisEn | input | 1 | Enables a discharge on a zero-run event |
| capDisEn | input | 1 | Enables a discharge on the request input |
| capDisReq | input | 1 | Discharge request from the second source |
| irqEn | input | 1 | Enables the link-idle interrupt |
| zeroThresh | input | THRESH_W | Threshold code; n means n+1 zeros |
| disPeriod | input | PERIOD_W | Pulse length in clocks (0 counts as 1) |
| irqClear | input | 1 | Clears the sticky interrupt |
| dischargePin | output | 1 | Direction pin, 1 during a discharge |
| idleIrq | output | 1 | Sticky link-idle interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a zero-run event landing in the same cycle as an interrupt clear. The second is a trigger arriving in the last cycle of a running pulse. Each needs a bit run of the exact length to end on a chosen cycle. Directed sequences build these runs explicitly. Seeded random stimulus then runs with high zero-bit density, short thresholds and frequent clears and requests, so both coincidences recur many times against a cycle-level reference model.

// File: rtl/zdcPkg.sv
`timescale 1ns/1ps
package zdcPkg;
  typedef struct packed {
    logic startPulse;
    logic setIrq;
  } zdcStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRIVE = 1'b1
  } zdcState_t;
endpackage

// File: rtl/zdcDatapath.sv
`timescale 1ns/1ps
module zdcDatapath
  import zdcPkg::*;
#(
  parameter int THRESH_W = 3,
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitValid,
  input  logic                bitData,
  input  logic                zeroDisEnIn,
  input  logic                capDisEnIn,
  input  logic                capDisReq,
  input  logic                irqEnIn,
  input  logic [THRESH_W-1:0] threshIn,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic                irqClear,
  input  zdcStrobe_t          strobe,
  output logic                zeroHit,
  output logic                zeroDisEnQ,
  output logic                irqEnQ,
  output logic                capHit,
  output logic                timerLast,
  output logic                idleIrq
);
  localparam int CNT_W = $clog2((1 << THRESH_W) + 1);

  logic                capDisEnQ;
  logic [THRESH_W-1:0] threshQ;
  logic [PERIOD_W-1:0] periodQ;
  logic [CNT_W-1:0]    zeroCnt;
  logic [CNT_W-1:0]    target;
  logic [PERIOD_W-1:0] timer;
  logic [PERIOD_W-1:0] loadLen;

  // configuration shadow, defaults on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroDisEnQ <= 1'b0;
      capDisEnQ  <= 1'b0;
      irqEnQ     <= 1'b0;
      threshQ    <= '0;
      periodQ    <= '0;
    end else begin
      zeroDisEnQ <= zeroDisEnIn;
      capDisEnQ  <= capDisEnIn;
      irqEnQ     <= irqEnIn;
      threshQ    <= threshIn;
      periodQ    <= periodIn;
    end
  end

  assign target  = CNT_W'(threshQ) + CNT_W'(1);
  assign zeroHit = bitValid && !bitData && (zeroCnt == target - CNT_W'(1));
  assign capHit  = capDisReq && capDisEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroCnt <= '0;
    end else if (bitValid) begin
      if (bitData)
        zeroCnt <= '0;
      else if (zeroCnt < target)
        zeroCnt <= zeroCnt + CNT_W'(1);
    end
  end

  assign loadLen   = (periodQ == '0) ? PERIOD_W'(1) : periodQ;
  assign timerLast = (timer == PERIOD_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      timer <= '0;
    else if (strobe.startPulse)
      timer <= loadLen;
    else if (timer != '0)
      timer <= timer - PERIOD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      idleIrq <= 1'b0;
    else if (strobe.setIrq)
      idleIrq <= 1'b1;
    else if (irqClear)
      idleIrq <= 1'b0;
  end
endmodule

// File: rtl/zdcControl.sv
`timescale 1ns/1ps
module zdcControl
  import zdcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       zeroHit,
  input  logic       zeroDisEnQ,
  input  logic       irqEnQ,
  input  logic       capHit,
  input  logic       timerLast,
  output zdcStrobe_t strobe,
  output logic       dischargePin
);
  zdcState_t state, stateNext;
  logic busy;

  assign busy = (state == ST_DRIVE);

  always_comb begin
    strobe.startPulse = !busy && ((zeroHit && zeroDisEnQ) || capHit);
    strobe.setIrq     = zeroHit && irqEnQ;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobe.startPulse) stateNext = ST_DRIVE;
      ST_DRIVE: if (timerLast)         stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign dischargePin = busy;
endmodule

// File: rtl/zeroDischargeCtrl.sv
`timescale 1ns/1ps
module zeroDischargeCtrl
  import zdcPkg::*;
#(
  parameter int THRESH_W = 3,
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitValid,
  input  logic                bitData,
  input  logic                zeroDisEn,
  input  logic                capDisEn,
  input  logic                capDisReq,
  input  logic                irqEn,
  input  logic [THRESH_W-1:0] zeroThresh,
  input  logic [PERIOD_W-1:0] disPeriod,
  input  logic                irqClear,
  output logic                dischargePin,
  output logic                idleIrq
);
  zdcStrobe_t strobe;
  logic zeroHit, zeroDisEnQ, irqEnQ, capHit, timerLast;

  zdcDatapath #(.THRESH_W(THRESH_W), .PERIOD_W(PERIOD_W)) u_dp (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData),
    .zeroDisEnIn(zeroDisEn), .capDisEnIn(capDisEn), .capDisReq(capDisReq),
    .irqEnIn(irqEn), .threshIn(zeroThresh), .periodIn(disPeriod),
    .irqClear(irqClear), .strobe(strobe), .zeroHit(zeroHit),
    .zeroDisEnQ(zeroDisEnQ), .irqEnQ(irqEnQ), .capHit(capHit),
    .timerLast(timerLast), .idleIrq(idleIrq)
  );

  zdcControl u_ctl (
    .clk(clk), .rstN(rstN), .zeroHit(zeroHit), .zeroDisEnQ(zeroDisEnQ),
    .irqEnQ(irqEnQ), .capHit(capHit), .timerLast(timerLast),
    .strobe(strobe), .dischargePin(dischargePin)
  );
endmodule

// File: rtl/zdcChecker.sv
`timescale 1ns/1ps
module zdcChecker #(
  parameter int PERIOD_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic bitData,
  input logic capDisReq,
  input logic irqClear,
  input logic dischargePin,
  input logic idleIrq
);
  localparam int MAX_LEN = (1 << PERIOD_W) - 1;
  logic [PERIOD_W:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             highCnt <= '0;
    else if (dischargePin) highCnt <= highCnt + 1'b1;
    else                   highCnt <= '0;
  end

  // R8: a pulse never outlasts the largest programmable length
  always_ff @(posedge clk) begin
    if (rstN) a_r8_pulse_bounded: assert (int'(highCnt) <= MAX_LEN);
  end

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    idleIrq && !irqClear |=> idleIrq);

  a_r7_irq_clears: assert property (@(posedge clk) disable iff (!rstN)
    idleIrq && irqClear && !bitValid |=> !idleIrq);

  a_r6_irq_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleIrq) |-> $past(bitValid && !bitData));

  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dischargePin) |-> $past(capDisReq || (bitValid && !bitData)));
endmodule

bind zeroDischargeCtrl zdcChecker #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData),
  .capDisReq(capDisReq), .irqClear(irqClear),
  .dischargePin(dischargePin), .idleIrq(idleIrq)
);

// File: tb/test_zeroDischargeCtrl.sv
`timescale 1ns/1ps
module test_zeroDischargeCtrl;
  localparam int TW = 3;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 0, bitData = 0, zeroDisEn = 0, capDisEn = 0, capDisReq = 0;
  logic irqEn = 0, irqClear = 0;
  logic [TW-1:0] zeroThresh = '0;
  logic [PW-1:0] disPeriod = '0;
  logic dischargePin, idleIrq;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  zeroDischargeCtrl #(.THRESH_W(TW), .PERIOD_W(PW)) i_zeroDischargeCtrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData),
    .zeroDisEn(zeroDisEn), .capDisEn(capDisEn), .capDisReq(capDisReq),
    .irqEn(irqEn), .zeroThresh(zeroThresh), .disPeriod(disPeriod),
    .irqClear(irqClear), .dischargePin(dischargePin), .idleIrq(idleIrq)
  );

  // reference model built from the requirements
  logic mZen, mCen, mIen, mIrq;
  logic [TW-1:0] mThr;
  logic [PW-1:0] mPer, mTimer;
  int mCnt;

  function automatic logic modelHit(int cnt, logic [TW-1:0] thr, logic v, logic d);
    return v && !d && (cnt == int'(thr));
  endfunction

  function automatic logic [PW-1:0] pulseLen(logic [PW-1:0] p);
    return (p == '0) ? PW'(1) : p;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mZen <= 0; mCen <= 0; mIen <= 0; mIrq <= 0;
      mThr <= '0; mPer <= '0; mTimer <= '0; mCnt <= 0;
    end else begin
      logic hit, start;
      hit   = modelHit(mCnt, mThr, bitValid, bitData);
      start = (mTimer == '0) && ((hit && mZen) || (capDisReq && mCen));
      if (start)              mTimer <= pulseLen(mPer);
      else if (mTimer != '0)  mTimer <= mTimer - 1'b1;
      mIrq <= (hit && mIen) || (mIrq && !irqClear);
      if (bitValid) mCnt <= bitData ? 0 : ((mCnt < int'(mThr) + 1) ? mCnt + 1 : mCnt);
      mZen <= zeroDisEn; mCen <= capDisEn; mIen <= irqEn;
      mThr <= zeroThresh; mPer <= disPeriod;
    end
  end

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-level comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R8 pin vs model", dischargePin, mTimer != '0);
      check("R6 irq vs model", idleIrq, mIrq);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      summary();
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBit(logic d);
    bitValid = 1; bitData = d; tick(); bitValid = 0; bitData = 0;
  endtask

  task automatic sendZeros(int n);
    for (int i = 0; i < n; i++) sendBit(0);
  endtask

  function automatic int measurePulse();
    return 0;
  endfunction

  task automatic countHigh(output int n);
    n = 0;
    while (dischargePin && n < 400) begin n++; tick(); end
  endtask

  task automatic clearIrq();
    irqClear = 1; tick(); irqClear = 0;
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    tick(2);
    check("R1 pin in reset", dischargePin, 1'b0);
    check("R1 irq in reset", idleIrq, 1'b0);
    rstN = 1; tick(2);
    // R1: defaults keep both actions off
    sendZeros(3);
    check("R1 default no irq", idleIrq, 1'b0);
    check("R1 default no pin", dischargePin, 1'b0);

    // R3/R5/R6: threshold code 2 -> three zeros, irq on, discharge off
    zeroThresh = 3'd2; irqEn = 1; tick(2);
    sendBit(1); sendZeros(2);
    check("R3 two zeros no event", idleIrq, 1'b0);
    sendBit(0);
    check("R3 third zero raises irq", idleIrq, 1'b1);
    check("R5 no pulse when disabled", dischargePin, 1'b0);
    clearIrq();
    check("R7 clear drops irq", idleIrq, 1'b0);
    // R4: run keeps going, no second event
    sendZeros(5);
    check("R4 saturated run no event", idleIrq, 1'b0);
    // R2: invalid cycles do not advance the count
    sendBit(1); sendZeros(2);
    bitData = 0; tick(6);
    check("R2 invalid cycles ignored", idleIrq, 1'b0);
    sendBit(1); sendZeros(2);
    check("R2 one bit clears count", idleIrq, 1'b0);
    sendBit(0);
    check("R2 count resumes", idleIrq, 1'b1);
    // R7: event and clear together leave the flag set
    sendBit(1); sendZeros(2);
    irqClear = 1; sendBit(0); irqClear = 0;
    check("R7 clear with event keeps irq", idleIrq, 1'b1);
    clearIrq();

    // R5/R8: discharge with period 4
    zeroDisEn = 1; disPeriod = 8'd4; tick(2);
    sendBit(1); sendZeros(3);
    check("R5 pulse starts", dischargePin, 1'b1);
    countHigh(n);
    check("R8 length 4", n == 4, 1'b1);
    clearIrq();
    // R8: period 0 acts as 1
    disPeriod = 8'd0; zeroThresh = 3'd0; tick(2);
    sendBit(1); sendBit(0);
    countHigh(n);
    check("R8 period zero is one clock", n == 1, 1'b1);
    clearIrq();

    // R9: second source
    zeroDisEn = 0; disPeriod = 8'd3; tick(2);
    capDisReq = 1; tick(); capDisReq = 0;
    check("R9 disabled request ignored", dischargePin, 1'b0);
    capDisEn = 1; tick(2);
    capDisReq = 1; tick(); capDisReq = 0;
    countHigh(n);
    check("R9 request pulse length 3", n == 3, 1'b1);
    // R10: retrigger mid pulse does not stretch
    disPeriod = 8'd6; tick(2);
    capDisReq = 1; tick(); capDisReq = 0;
    tick(2);
    capDisReq = 1; tick(); capDisReq = 0;
    countHigh(n);
    check("R10 no stretch", n == 3, 1'b1);
    capDisEn = 0;

    // R11: enable changed in the same cycle as an event is not yet seen
    irqEn = 0; zeroThresh = 3'd0; tick(2);
    sendBit(1);
    irqEn = 1; sendBit(0);
    check("R11 old enable applies", idleIrq, 1'b0);
    sendBit(1); sendBit(0);
    check("R11 new enable applies", idleIrq, 1'b1);
    clearIrq();

    // seeded random phase, compared each cycle with the model
    for (int c = 0; c < 20000; c++) begin
      bitValid  = ($urandom % 2) == 0;
      bitData   = ($urandom % 4) == 0;
      capDisReq = ($urandom % 20) == 0;
      irqClear  = ($urandom % 8) == 0;
      if (($urandom % 64) == 0) begin
        zeroDisEn  = $urandom % 2;
        capDisEn   = $urandom % 2;
        irqEn      = $urandom % 2;
        zeroThresh = TW'($urandom % 4);
        disPeriod  = PW'($urandom % 8);
      end
      tick();
    end
    bitValid = 0; capDisReq = 0; irqClear = 0;
    tick(20);
    summary();
  end
endmodule